// File: doc/BRIEF.md
# Debug Exception Interrupt Controller

This block sits beside a processor core's exception logic. It records debug events into a sticky status register. It decides in which cycle a debug interrupt is taken. On entry it produces the state the core loads: the saved return address, a copy of the machine state, the new machine state and the fetch address of the debug handler. The address comparators and the pipeline are outside the block. The pipeline supplies one strobe per event class each cycle, together with four candidate addresses:

- the address of the instruction that caused the event;
- the address of the instruction after it;
- the address that would execute next;
- the vector address of an interrupt that has just been taken.

An event that arrives while debug interrupts are enabled is delivered one cycle later. The return address depends on the class of the event, and a fixed priority applies when classes coincide. An event logged while interrupts are disabled stays pending. It is delivered at a later synchronizing event, once both enable bits are 1, and then the next-instruction address is saved. Software clears status bits by writing ones.

Top module: `dbg_irq_ctrl`

## Requirements
- R1: Status bit n records event strobe bit n. The bit layout is: bits 0 and 1 instruction compare; bits 2 to 5 data compare (channel one read, channel one write, channel two read, channel two write); bit 6 trap; bit 7 branch taken; bit 8 instruction complete; bit 9 interrupt taken; bit 10 return from interrupt; bit 11 unconditional. While `idm_en` is 0 no bit is ever set and `take` never rises, whatever the other inputs are.
- R2: When `idm_en` is 1, `msr_in` bit 9 (debug enable) is 1, `hipri_pend` is 0 and at least one strobe is high in cycle t, `take` is 1 in cycle t+1. If either enable is 0 or `hipri_pend` is 1 in cycle t, `take` is 0 in cycle t+1.
- R3: When the winning class is an instruction compare, data compare, trap or branch event, `save_pc` is the value of `ev_pc`.
- R4: When the winning class is instruction complete or return from interrupt, `save_pc` is the value of `ev_next_pc`.
- R5: When the winning class is unconditional, `save_pc` is the value of `next_pc`.
- R6: When the winning class is interrupt taken, `save_pc` is the value of `irq_vec`.
- R7: When several classes fire in one cycle, the winner is chosen in this order: interrupt taken, then return, then compare/trap/branch, then instruction complete, then unconditional.
- R8: If no strobe is high, at least one status bit is set, both enables are 1, `hipri_pend` is 0 and `sync_evt` is 1 in cycle t, then `take` is 1 in cycle t+1 with `save_pc` equal to `next_pc`. Without `sync_evt`, a pending bit alone causes no interrupt.
- R9: On entry, `save_msr` receives the whole `msr_in` value. `msr_out` keeps only bit 12 (machine-check enable) of `msr_in` and has every other bit 0.
- R10: On entry, `vec_addr` is `{vbase_hi, voff, 4'b0000}`. Here `vbase_hi` carries the top 16 bits of the vector prefix register and `voff` carries bits 15:4 of the debug vector offset register.
- R11: With `clr_we` high, each bit set in `clr_mask` clears the matching status bit on the next cycle. A strobe on the same bit in the same cycle with `idm_en` 1 wins, and the bit stays set. Clearing also works while `idm_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idm_en | input | 1 | Internal debug mode enable |
| msr_in | input | 32 | Current machine state |
| hipri_pend | input | 1 | A higher-priority interrupt is pending |
| sync_evt | input | 1 | Synchronizing event strobe |
| ev | input | 12 | Per-class event strobes |
| ev_pc | input | 32 | Address of the causing instruction |
| ev_next_pc | input | 32 | Address after the causing instruction |
| next_pc | input | 32 | Address that would execute next |
| irq_vec | input | 32 | Vector of the interrupt just taken |
| vbase_hi | input | 16 | Upper half of the vector prefix register |
| voff | input | 12 | Bits 15:4 of the debug vector offset |
| clr_we | input | 1 | Status clear write strobe |
| clr_mask | input | 12 | Ones select status bits to clear |
| status | output | 12 | Sticky debug status |
| take | output | 1 | Debug interrupt taken this cycle |
| save_pc | output | 32 | Saved return address |
| save_msr | output | 32 | Saved machine state |
| msr_out | output | 32 | New machine state |
| vec_addr | output | 32 | Debug handler fetch address |

## Verification
A wrong status bit shows at the `status` port one cycle after the strobe or the clear that disturbed it. If the bit was lost, a deferred interrupt also goes missing at the next synchronizing event. A wrong source choice for the return address shows only in the cycle of `take`, so events are driven alone, in chosen pairs and in random mixes, and `save_pc` is compared each time. Wrong gating by the enables or the pending flag shows as a `take` in the very next cycle, or as a missing one.

// File: rtl/dbg_irq_pkg.sv
package dbg_irq_pkg;

    localparam int unsigned NEV = 12;

    localparam int unsigned EV_IA1  = 0;
    localparam int unsigned EV_IA2  = 1;
    localparam int unsigned EV_D1R  = 2;
    localparam int unsigned EV_D1W  = 3;
    localparam int unsigned EV_D2R  = 4;
    localparam int unsigned EV_D2W  = 5;
    localparam int unsigned EV_TRP  = 6;
    localparam int unsigned EV_BRT  = 7;
    localparam int unsigned EV_CMP  = 8;
    localparam int unsigned EV_IRQ  = 9;
    localparam int unsigned EV_RET  = 10;
    localparam int unsigned EV_UNC  = 11;

    typedef logic [NEV-1:0] ev_vec_t;

    // Classes whose return address is the causing instruction itself
    localparam ev_vec_t CAUSE_MASK = ev_vec_t'(12'h0FF);

    typedef enum logic [1:0] {
        SRC_VECTOR,
        SRC_FOLLOW,
        SRC_CAUSE,
        SRC_NEXT
    } pc_src_e;

    // Fixed priority among simultaneous event classes
    function automatic pc_src_e pick_src(input ev_vec_t e);
        pc_src_e s;
        if (e[EV_IRQ])                 s = SRC_VECTOR;
        else if (e[EV_RET])            s = SRC_FOLLOW;
        else if (|(e & CAUSE_MASK))    s = SRC_CAUSE;
        else if (e[EV_CMP])            s = SRC_FOLLOW;
        else                           s = SRC_NEXT;
        return s;
    endfunction

endpackage

// File: rtl/dbg_sticky_status.sv
module dbg_sticky_status
    import dbg_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    log_en,
    input  ev_vec_t ev,
    input  logic    clr_we,
    input  ev_vec_t clr_mask,
    output ev_vec_t status
);

    for (genvar i = 0; i < NEV; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                status[i] <= 1'b0;
            else if (log_en && ev[i])
                status[i] <= 1'b1;
            else if (clr_we && clr_mask[i])
                status[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/dbg_take_ctrl.sv
module dbg_take_ctrl
    import dbg_irq_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          log_en,
    input  logic          de,
    input  logic          hipri,
    input  logic          sync,
    input  ev_vec_t       ev,
    input  ev_vec_t       status,
    input  logic [AW-1:0] a_cause,
    input  logic [AW-1:0] a_follow,
    input  logic [AW-1:0] a_next,
    input  logic [AW-1:0] a_vector,
    output logic          take_now,
    output logic [AW-1:0] ret_pc
);

    logic    fresh;
    logic    deferred;
    logic    gate;
    pc_src_e src;

    always_comb begin
        fresh    = log_en && (|ev);
        deferred = sync && (|status);
        gate     = log_en && de && !hipri;
        take_now = gate && (fresh || deferred);
        src      = fresh ? pick_src(ev) : SRC_NEXT;
        unique case (src)
            SRC_VECTOR: ret_pc = a_vector;
            SRC_FOLLOW: ret_pc = a_follow;
            SRC_CAUSE:  ret_pc = a_cause;
            default:    ret_pc = a_next;
        endcase
    end

endmodule

// File: rtl/dbg_entry_regs.sv
module dbg_entry_regs #(
    parameter int unsigned AW     = 32,
    parameter int unsigned MW     = 32,
    parameter int unsigned ME_BIT = 12,
    parameter int unsigned PFX_W  = 16,
    parameter int unsigned ALIGN  = 4,
    localparam int unsigned OFF_W = AW - PFX_W - ALIGN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_now,
    input  logic [AW-1:0]    ret_pc,
    input  logic [MW-1:0]    msr_in,
    input  logic [PFX_W-1:0] vbase_hi,
    input  logic [OFF_W-1:0] voff,
    output logic             take,
    output logic [AW-1:0]    save_pc,
    output logic [MW-1:0]    save_msr,
    output logic [MW-1:0]    msr_out,
    output logic [AW-1:0]    vec_addr
);

    localparam logic [MW-1:0] KEEP = MW'(1) << ME_BIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            take     <= 1'b0;
            save_pc  <= '0;
            save_msr <= '0;
            msr_out  <= '0;
            vec_addr <= '0;
        end else begin
            take <= take_now;
            if (take_now) begin
                save_pc  <= ret_pc;
                save_msr <= msr_in;
                msr_out  <= msr_in & KEEP;
                vec_addr <= {vbase_hi, voff, {ALIGN{1'b0}}};
            end
        end
    end

endmodule

// File: rtl/dbg_irq_ctrl.sv
module dbg_irq_ctrl
    import dbg_irq_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned MW     = 32,
    parameter int unsigned DE_BIT = 9,
    parameter int unsigned ME_BIT = 12,
    parameter int unsigned PFX_W  = 16,
    parameter int unsigned ALIGN  = 4,
    localparam int unsigned OFF_W = AW - PFX_W - ALIGN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idm_en,
    input  logic [MW-1:0]    msr_in,
    input  logic             hipri_pend,
    input  logic             sync_evt,
    input  logic [NEV-1:0]   ev,
    input  logic [AW-1:0]    ev_pc,
    input  logic [AW-1:0]    ev_next_pc,
    input  logic [AW-1:0]    next_pc,
    input  logic [AW-1:0]    irq_vec,
    input  logic [PFX_W-1:0] vbase_hi,
    input  logic [OFF_W-1:0] voff,
    input  logic             clr_we,
    input  logic [NEV-1:0]   clr_mask,
    output logic [NEV-1:0]   status,
    output logic             take,
    output logic [AW-1:0]    save_pc,
    output logic [MW-1:0]    save_msr,
    output logic [MW-1:0]    msr_out,
    output logic [AW-1:0]    vec_addr
);

    logic          take_now;
    logic [AW-1:0] ret_pc;

    dbg_sticky_status u_status (
        .clk      (clk),
        .rst      (rst),
        .log_en   (idm_en),
        .ev       (ev),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .status   (status)
    );

    dbg_take_ctrl #(.AW(AW)) u_take (
        .log_en   (idm_en),
        .de       (msr_in[DE_BIT]),
        .hipri    (hipri_pend),
        .sync     (sync_evt),
        .ev       (ev),
        .status   (status),
        .a_cause  (ev_pc),
        .a_follow (ev_next_pc),
        .a_next   (next_pc),
        .a_vector (irq_vec),
        .take_now (take_now),
        .ret_pc   (ret_pc)
    );

    dbg_entry_regs #(
        .AW(AW), .MW(MW), .ME_BIT(ME_BIT), .PFX_W(PFX_W), .ALIGN(ALIGN)
    ) u_entry (
        .clk      (clk),
        .rst      (rst),
        .take_now (take_now),
        .ret_pc   (ret_pc),
        .msr_in   (msr_in),
        .vbase_hi (vbase_hi),
        .voff     (voff),
        .take     (take),
        .save_pc  (save_pc),
        .save_msr (save_msr),
        .msr_out  (msr_out),
        .vec_addr (vec_addr)
    );

endmodule

// File: rtl/dbg_irq_chk.sv
module dbg_irq_chk #(
    parameter int unsigned AW     = 32,
    parameter int unsigned MW     = 32,
    parameter int unsigned NEV    = 12,
    parameter int unsigned DE_BIT = 9,
    parameter int unsigned ME_BIT = 12,
    parameter int unsigned PFX_W  = 16,
    parameter int unsigned OFF_W  = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             idm_en,
    input logic [MW-1:0]    msr_in,
    input logic             hipri_pend,
    input logic [NEV-1:0]   ev,
    input logic             clr_we,
    input logic [NEV-1:0]   clr_mask,
    input logic [PFX_W-1:0] vbase_hi,
    input logic [OFF_W-1:0] voff,
    input logic [NEV-1:0]   status,
    input logic             take,
    input logic [MW-1:0]    save_msr,
    input logic [MW-1:0]    msr_out,
    input logic [AW-1:0]    vec_addr
);

    AST_IDM_OFF_NO_LOG: assert property (@(posedge clk) disable iff (rst)
        !idm_en |=> ((status & ~$past(status)) == '0)); // R1

    AST_IDM_OFF_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        !idm_en |=> !take); // R1

    AST_GATED_TAKE: assert property (@(posedge clk) disable iff (rst)
        !(idm_en && msr_in[DE_BIT] && !hipri_pend) |=> !take); // R2

    AST_TAKE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ((status == '0) && (ev == '0)) |=> !take); // R2

    AST_SAVED_STATE: assert property (@(posedge clk) disable iff (rst)
        take |-> (save_msr == $past(msr_in))); // R9

    AST_NEW_STATE: assert property (@(posedge clk) disable iff (rst)
        take |-> ((msr_out & ~(MW'(1) << ME_BIT)) == '0
                  && msr_out[ME_BIT] == $past(msr_in[ME_BIT]))); // R9

    AST_VECTOR_ADDR: assert property (@(posedge clk) disable iff (rst)
        take |-> (vec_addr[AW-1 -: PFX_W] == $past(vbase_hi)
                  && vec_addr[AW-PFX_W-1 -: OFF_W] == $past(voff)
                  && vec_addr[AW-PFX_W-OFF_W-1:0] == '0)); // R10

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (idm_en && clr_we) |=> ((status & $past(ev)) == $past(ev))); // R11

endmodule

bind dbg_irq_ctrl dbg_irq_chk #(
    .AW(AW), .MW(MW), .NEV(dbg_irq_pkg::NEV), .DE_BIT(DE_BIT),
    .ME_BIT(ME_BIT), .PFX_W(PFX_W), .OFF_W(OFF_W)
) u_chk (
    .clk(clk), .rst(rst), .idm_en(idm_en), .msr_in(msr_in),
    .hipri_pend(hipri_pend), .ev(ev), .clr_we(clr_we), .clr_mask(clr_mask),
    .vbase_hi(vbase_hi), .voff(voff), .status(status), .take(take),
    .save_msr(save_msr), .msr_out(msr_out), .vec_addr(vec_addr)
);

// File: tb/dbg_irq_ctrl_test.sv
`timescale 1ns/1ps
module dbg_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        idm_en;
    logic [31:0] msr_in;
    logic        hipri_pend;
    logic        sync_evt;
    logic [11:0] ev;
    logic [31:0] ev_pc, ev_next_pc, next_pc, irq_vec;
    logic [15:0] vbase_hi;
    logic [11:0] voff;
    logic        clr_we;
    logic [11:0] clr_mask;
    logic [11:0] status;
    logic        take;
    logic [31:0] save_pc, save_msr, msr_out, vec_addr;

    int checks = 0;
    int errors = 0;
    logic [11:0] m_stat;
    bit finished = 0;

    always #5 clk = ~clk;

    dbg_irq_ctrl uut (
        .clk(clk), .rst(rst), .idm_en(idm_en), .msr_in(msr_in),
        .hipri_pend(hipri_pend), .sync_evt(sync_evt), .ev(ev),
        .ev_pc(ev_pc), .ev_next_pc(ev_next_pc), .next_pc(next_pc),
        .irq_vec(irq_vec), .vbase_hi(vbase_hi), .voff(voff),
        .clr_we(clr_we), .clr_mask(clr_mask), .status(status), .take(take),
        .save_pc(save_pc), .save_msr(save_msr), .msr_out(msr_out),
        .vec_addr(vec_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected return address and the requirement it belongs to
    function automatic logic [31:0] exp_pc(input logic [11:0] e, input bit fresh,
                                           output string tag);
        if (!fresh)                 begin tag = "R8"; return next_pc;    end
        if (e[9])                   begin tag = "R6"; return irq_vec;    end
        if (e[10])                  begin tag = "R4"; return ev_next_pc; end
        if (e[7:0] != 0)            begin tag = "R3"; return ev_pc;      end
        if (e[8])                   begin tag = "R4"; return ev_next_pc; end
        tag = "R5";
        return next_pc;
    endfunction

    task automatic step(input logic [11:0] e, input bit idm, input bit de,
                        input bit hp, input bit sy, input bit cw, input logic [11:0] cm);
        bit fresh, etake;
        logic [31:0] epc, emsr;
        string tag;
        ev = e; idm_en = idm; hipri_pend = hp; sync_evt = sy;
        clr_we = cw; clr_mask = cm;
        emsr = $urandom; emsr[9] = de; msr_in = emsr;
        ev_pc = $urandom; ev_next_pc = $urandom; next_pc = $urandom; irq_vec = $urandom;
        vbase_hi = 16'($urandom); voff = 12'($urandom);
        fresh = idm && (e != 0);
        etake = idm && de && !hp && (fresh || (sy && m_stat != 0));
        epc = exp_pc(e, fresh, tag);
        if ($countones(e) > 1 && fresh) tag = {tag, "/R7"};
        if (cw) m_stat = m_stat & ~cm;
        if (idm) m_stat = m_stat | e;
        @(posedge clk);
        @(negedge clk);
        chk(idm ? "R11 status" : "R1 status", 32'(status), 32'(m_stat));
        chk(idm ? "R2/R8 take" : "R1 take", 32'(take), 32'(etake));
        if (etake) begin
            chk({tag, " save_pc"}, save_pc, epc);
            chk("R9 save_msr", save_msr, emsr);
            chk("R9 msr_out", msr_out, emsr & 32'h0000_1000);
            chk("R10 vec_addr", vec_addr, {vbase_hi, voff, 4'h0});
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0417));
        rst = 1'b1; m_stat = '0;
        ev = '0; idm_en = 0; msr_in = '0; hipri_pend = 0; sync_evt = 0;
        ev_pc = '0; ev_next_pc = '0; next_pc = '0; irq_vec = '0;
        vbase_hi = '0; voff = '0; clr_we = 0; clr_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset status", 32'(status), 0);
        chk("R2 reset take", 32'(take), 0);

        // R1: logging and taking off with the debug mode bit clear
        step(12'hFFF, 0, 1, 0, 1, 0, 12'h000);
        // R3: lone compare event
        step(12'h001, 1, 1, 0, 0, 0, 12'h000);
        // R11: clear
        step(12'h000, 1, 0, 0, 0, 1, 12'hFFF);
        // R3/R4/R5/R6: each class alone
        for (int i = 0; i < 12; i++) step(12'(1 << i), 1, 1, 0, 0, 1, 12'hFFF);
        // R7: priority among coincident classes
        step(12'hFFF, 1, 1, 0, 0, 1, 12'hFFF);
        step(12'hD20, 1, 1, 0, 0, 1, 12'hFFF);
        step(12'h980, 1, 1, 0, 0, 1, 12'hFFF);
        step(12'h900, 1, 1, 0, 0, 1, 12'hFFF);
        // R8: deferred delivery
        step(12'h000, 1, 0, 0, 0, 1, 12'hFFF);
        step(12'h040, 1, 0, 0, 0, 0, 12'h000);
        step(12'h000, 1, 1, 0, 0, 0, 12'h000);
        step(12'h000, 1, 1, 1, 1, 0, 12'h000);
        step(12'h000, 1, 1, 0, 1, 0, 12'h000);
        // R2: higher-priority interrupt blocks a fresh event
        step(12'h002, 1, 1, 1, 0, 0, 12'h000);
        // R11: event beats clear on the same bit; clear works with mode off
        step(12'h020, 1, 0, 0, 0, 1, 12'hFFF);
        step(12'h000, 0, 0, 0, 0, 1, 12'h020);

        for (int n = 0; n < 3000; n++) begin
            logic [11:0] e;
            e = ($urandom % 3 == 0) ? (12'($urandom) & 12'($urandom) & 12'($urandom)) : 12'h000;
            step(e, ($urandom % 10) != 0, ($urandom % 10) < 7, ($urandom % 5) == 0,
                 ($urandom % 4) == 0, ($urandom % 5) == 0, 12'($urandom));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule